// File: doc/BRIEF.md
# Add-or-OR Accumulating Output Register

This block holds a small unsigned result in one register with a clock enable. Two operands arrive in parallel with two operation strobes. On a clock edge where the add strobe is high, the register takes the sum of the operands. On an edge where the OR strobe is high, it takes their bitwise OR. On every other edge the enable stays low and the register keeps its value, whatever the operands do.

A single multiplexer steers either the adder result or the OR result into the register. The select comes straight from the add strobe. The clock enable is the OR of the two strobes. The surrounding logic must never raise both strobes in the same cycle; an assertion inside the block flags that illegal case. A synchronous, active-high reset clears the register.

Top module: `aor_accum`

## Requirements
- R1: With `rst` high at a rising clock edge, `result` reads zero after that edge, even if a strobe is high in the same cycle.
- R2: With `add_stb` high and `rst` low at a rising edge, `result` becomes (`op_a` + `op_b`) modulo 2^WIDTH, so any carry out of the top bit is dropped. For example, 5 + 6 gives 3 with the default WIDTH of 3.
- R3: With `or_stb` high and `rst` low at a rising edge, `result` becomes `op_a` bitwise-OR `op_b`.
- R4: With both strobes low and `rst` low at a rising edge, `result` keeps its previous value, even when the operands change.
- R5: A loaded value appears on `result` after exactly one rising edge, and `result` is driven directly by the register.
- R6: `add_stb` and `or_stb` are never high in the same cycle. This is an input rule, checked by an assertion; the result for that case is not defined.
- R7: Operands and result are unsigned and WIDTH bits wide. WIDTH defaults to 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear |
| op_a | input | WIDTH | First unsigned operand |
| op_b | input | WIDTH | Second unsigned operand |
| add_stb | input | 1 | Load the modulo sum on this edge |
| or_stb | input | 1 | Load the bitwise OR on this edge |
| result | output | WIDTH | Registered result |

## Verification
Reset and a load strobe can fall in the same cycle. The bench provokes this by raising `rst` together with `add_stb` on an operand pair whose sum is nonzero, then requires zero on `result`, which shows that the clear wins. A load and the idle hold also meet at every strobe edge. After each load the bench changes the operands with both strobes low and requires the loaded value to stay. All 64 operand pairs are swept under each operation, with the expected values computed arithmetically in the bench.

// File: rtl/aor_pkg.sv
package aor_pkg;
  typedef enum logic {OP_OR = 1'b0, OP_ADD = 1'b1} op_sel_e;

  function automatic logic [7:0] fn_wrap_add(input logic [7:0] a, input logic [7:0] b, input int w);
    logic [8:0] full;
    logic [7:0] mask;
    full = {1'b0, a} + {1'b0, b};
    mask = 8'((9'd1 << w) - 9'd1);
    return full[7:0] & mask;
  endfunction

  function automatic logic [7:0] fn_bit_or(input logic [7:0] a, input logic [7:0] b);
    return a | b;
  endfunction
endpackage

// File: rtl/aor_opunit.sv
module aor_opunit #(
  parameter int WIDTH = 3
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  aor_pkg::op_sel_e sel,
  output logic [WIDTH-1:0] sum_o,
  output logic [WIDTH-1:0] or_o,
  output logic [WIDTH-1:0] mux_o
);
  import aor_pkg::*;
  localparam int PAD = 8 - WIDTH;

  logic [7:0] a_ext, b_ext, sum_ext, or_ext;

  assign a_ext   = {{PAD{1'b0}}, op_a};
  assign b_ext   = {{PAD{1'b0}}, op_b};
  assign sum_ext = fn_wrap_add(a_ext, b_ext, WIDTH);
  assign or_ext  = fn_bit_or(a_ext, b_ext);
  assign sum_o   = sum_ext[WIDTH-1:0];
  assign or_o    = or_ext[WIDTH-1:0];

  always_comb begin
    unique case (sel)
      OP_ADD:  mux_o = sum_o;
      default: mux_o = or_o;
    endcase
  end
endmodule

// File: rtl/aor_enreg.sv
module aor_enreg #(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)     q[i] <= 1'b0;
      else if (en) q[i] <= d[i];
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (q == '0)); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) !en |=> $stable(q)); // R4
endmodule

// File: rtl/aor_accum.sv
module aor_accum #(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             add_stb,
  input  logic             or_stb,
  output logic [WIDTH-1:0] result
);
  import aor_pkg::*;
  localparam int PAD = 8 - WIDTH;

  op_sel_e          sel_w;
  logic             load_en_w;
  logic [WIDTH-1:0] sum_w, or_w, next_w;

  assign sel_w     = add_stb ? OP_ADD : OP_OR;
  assign load_en_w = add_stb | or_stb;

  aor_opunit #(.WIDTH(WIDTH)) u_ops (
    .op_a  (op_a),
    .op_b  (op_b),
    .sel   (sel_w),
    .sum_o (sum_w),
    .or_o  (or_w),
    .mux_o (next_w)
  );

  aor_enreg #(.WIDTH(WIDTH)) u_reg (
    .clk (clk),
    .rst (rst),
    .en  (load_en_w),
    .d   (next_w),
    .q   (result)
  );

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) !(add_stb && or_stb)); // R6
  AST_ADD_LOAD: assert property (@(posedge clk) disable iff (rst)
    add_stb |=> (result == WIDTH'(fn_wrap_add({{PAD{1'b0}}, $past(op_a)}, {{PAD{1'b0}}, $past(op_b)}, WIDTH)))); // R2
  AST_OR_LOAD: assert property (@(posedge clk) disable iff (rst)
    or_stb |=> (result == ($past(op_a) | $past(op_b)))); // R3
endmodule

// File: tb/aor_accum_tb.sv
module aor_accum_tb_top;
  localparam int W = 3;
  localparam int N = 1 << W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic         add_stb = 1'b0, or_stb = 1'b0;
  logic [W-1:0] result;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  aor_accum #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b),
    .add_stb(add_stb), .or_stb(or_stb), .result(result)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic drive(input logic r, input int a, input int b, input logic ad, input logic o);
    @(negedge clk);
    rst = r; op_a = W'(a); op_b = W'(b); add_stb = ad; or_stb = o;
  endtask

  task automatic check(input string req, input logic [W-1:0] exp);
    checks++;
    if (result !== exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", req, result, exp);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL R5 watchdog expired got 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick();
    check("R1 reset state", '0);
    drive(0, 0, 0, 0, 0); tick();
    check("R1 idle after reset", '0);
    for (int a = 0; a < N; a++) begin
      for (int b = 0; b < N; b++) begin
        logic [W-1:0] s, o;
        s = W'((a + b) % N);
        o = W'(a | b);
        drive(0, a, b, 1, 0); tick();
        check("R2 R5 R7 add load", s);
        drive(0, (a + 3) % N, (b + 5) % N, 0, 0); tick();
        check("R4 hold after add", s);
        drive(0, a, b, 0, 1); tick();
        check("R3 R5 or load", o);
        drive(0, (a + 1) % N, (b + 2) % N, 0, 0); tick();
        check("R4 hold after or", o);
      end
    end
    drive(0, 5, 6, 1, 0); tick();
    check("R2 carry dropped 5+6", 3'd3);
    drive(0, 7, 7, 1, 0); tick();
    check("R2 carry dropped 7+7", 3'd6);
    drive(1, 4, 2, 1, 0); tick();
    check("R1 reset beats add", '0);
    drive(0, 1, 6, 0, 1); tick();
    check("R3 or after reset", 3'd7);
    drive(1, 3, 3, 0, 1); tick();
    check("R1 reset beats or", '0);
    drive(0, 0, 0, 0, 0); tick();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule